// File: doc/BRIEF.md
# USB Endpoint Interrupt Aggregator

This block gathers the interrupt-causing events of five USB device endpoints into per-endpoint flag registers. A packet engine drives single-cycle event strobes, one vector per event kind with one bit per endpoint, and each strobe sets its flag. Each endpoint also has an enable register. Every flag is ANDed with its enable, and the results are ORed into one summary interrupt bit for that endpoint. All summary bits are then ORed into a single endpoint interrupt line for the processor.

The events fall into two groups. Processing events are IN buffer ready, OUT data received and SETUP received. Exception events are stall, NAK sent on an IN, NAK sent on an OUT, overflow, and two events that count only on an isochronous endpoint: underflow, and a CRC error on an OUT transaction. The CRC error has no flag of its own and reuses the stall flag. Overflow and underflow live in a separate status register and share one flow-error enable.

Firmware reaches the registers through a small port. An endpoint-select index and a register-select code pick one register, which is read combinationally. A write to a flag or status register clears every bit written as 0. A write to the enable register loads it.

Top module: `ep_irq_agg`

## Requirements
- R1: During and after reset, every flag, status and enable register reads 0, and `ep_irq` and `ep_any_irq` are 0.
- R2: An event strobe sets its flag on the next clock edge, whatever the enable state. The flag register bit positions are: IN ready bit 0, stall bit 1, OUT received bit 2, SETUP received bit 3, NAK on OUT bit 4, NAK on IN bit 6. Bits 5 and 7 always read 0.
- R3: `ev_iso_crc` sets flag bit 1 only when `iso_mode` of that endpoint is 1. Otherwise it has no effect.
- R4: In the status register, overflow sets bit 6 in any mode. Underflow sets bit 5 only when `iso_mode` of that endpoint is 1. All other status bits read 0.
- R5: A write to the flag register clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. Writing 1 never sets a flag.
- R6: If an event strobe and a clearing write hit the same flag in the same cycle, the flag is 1 after the edge.
- R7: A write to the enable register loads the data on the next edge, with bit 5 forced to 0. Bits 0 to 4 and bit 6 enable the flag at the same position. Bit 7 is the flow-error enable.
- R8: `ep_irq[e]` is 1 exactly when some flag of endpoint e is 1 together with its enable bit, or when some status bit is 1 while enable bit 7 is 1. It follows the registers in the same cycle.
- R9: `ep_any_irq` is 1 exactly when at least one bit of `ep_irq` is 1.
- R10: `reg_sel` selects the register: 0 is flags, 1 is status, 2 is enable, 3 reads 0 and ignores writes. `ep_sel` picks endpoint 0 to 4. Values 5 to 7 read 0 and ignore writes. `rd_data` is combinational.
- R11: A write to the status register clears each status bit whose data bit is 0 and leaves the others unchanged. Writing 1 never sets a status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in_rdy | input | 5 | IN buffer ready strobe, one bit per endpoint |
| ev_out_rx | input | 5 | OUT data received strobe |
| ev_setup_rx | input | 5 | SETUP received strobe |
| ev_stall | input | 5 | Stall handshake sent strobe |
| ev_iso_crc | input | 5 | CRC error on an isochronous OUT strobe |
| ev_ovf | input | 5 | Overflow strobe |
| ev_udf | input | 5 | Underflow strobe |
| ev_nak_in | input | 5 | NAK sent on IN strobe |
| ev_nak_out | input | 5 | NAK sent on OUT strobe |
| iso_mode | input | 5 | Endpoint is isochronous |
| ep_sel | input | 3 | Endpoint index for the register port |
| reg_sel | input | 2 | Register select: 0 flags, 1 status, 2 enable, 3 none |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Selected register contents |
| ep_irq | output | 5 | Per-endpoint summary interrupt |
| ep_any_irq | output | 1 | OR of all endpoint summary interrupts |

## Verification
The bench hits a flag with an event strobe and a clearing write in the same cycle. A design where the clear wins would drop that event, so its flag would read 0 and its summary bit would stay low. It drives CRC-error and underflow strobes on endpoints that are not isochronous. A design without the mode gate would then show a stall or underflow bit, and possibly an interrupt, that the model does not expect. It writes all-ones to flag and status registers, writes to endpoint indices 5 to 7 and to register code 3, and checks that the single flow-error enable gates both overflow and underflow. A design with set-on-write, aliased out-of-range indices or a misplaced enable bit would show a wrong read value or a wrong interrupt.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  localparam int REG_W = 8;

  localparam int B_IN     = 0;
  localparam int B_STALL  = 1;
  localparam int B_OUT    = 2;
  localparam int B_SETUP  = 3;
  localparam int B_NAKOUT = 4;
  localparam int B_NAKIN  = 6;
  localparam int B_UDF    = 5;
  localparam int B_OVF    = 6;
  localparam int B_FLOWEN = 7;

  localparam logic [REG_W-1:0] FLAG_MASK = 8'h5F;
  localparam logic [REG_W-1:0] STAT_MASK = 8'h60;
  localparam logic [REG_W-1:0] EN_MASK   = 8'hDF;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_STAT = 2'd1,
    SEL_EN   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Clear-on-zero write, then hardware sets; a set beats a clear.
  function automatic logic [REG_W-1:0] clr0_next(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] set,
    input logic             wr_hit,
    input logic [REG_W-1:0] wdata,
    input logic [REG_W-1:0] mask
  );
    logic [REG_W-1:0] kept;
    kept = wr_hit ? (cur & wdata) : cur;
    return (kept | set) & mask;
  endfunction

  // Summary interrupt of one endpoint.
  function automatic logic ep_summary(
    input logic [REG_W-1:0] flags,
    input logic [REG_W-1:0] stat,
    input logic [REG_W-1:0] en
  );
    logic proc_hit;
    logic flow_hit;
    proc_hit = |(flags & en & FLAG_MASK);
    flow_hit = (|(stat & STAT_MASK)) & en[B_FLOWEN];
    return proc_hit | flow_hit;
  endfunction
endpackage

// File: rtl/ep_irq_slot.sv
module ep_irq_slot
  import ep_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_in_rdy,
  input  logic             ev_out_rx,
  input  logic             ev_setup_rx,
  input  logic             ev_stall,
  input  logic             ev_iso_crc,
  input  logic             ev_ovf,
  input  logic             ev_udf,
  input  logic             ev_nak_in,
  input  logic             ev_nak_out,
  input  logic             iso_mode,
  input  logic             wr_flag,
  input  logic             wr_stat,
  input  logic             wr_ena,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] flags_q,
  output logic [REG_W-1:0] stat_q,
  output logic [REG_W-1:0] en_q,
  output logic             irq
);
  logic [REG_W-1:0] flag_set;
  logic [REG_W-1:0] stat_set;

  always_comb begin
    flag_set           = '0;
    flag_set[B_IN]     = ev_in_rdy;
    flag_set[B_STALL]  = ev_stall | (ev_iso_crc & iso_mode);
    flag_set[B_OUT]    = ev_out_rx;
    flag_set[B_SETUP]  = ev_setup_rx;
    flag_set[B_NAKOUT] = ev_nak_out;
    flag_set[B_NAKIN]  = ev_nak_in;
  end

  always_comb begin
    stat_set        = '0;
    stat_set[B_OVF] = ev_ovf;
    stat_set[B_UDF] = ev_udf & iso_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      stat_q  <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= clr0_next(flags_q, flag_set, wr_flag, wdata, FLAG_MASK);
      stat_q  <= clr0_next(stat_q, stat_set, wr_stat, wdata, STAT_MASK);
      if (wr_ena) begin
        en_q <= wdata & EN_MASK;
      end
    end
  end

  assign irq = ep_summary(flags_q, stat_q, en_q);
endmodule

// File: rtl/ep_irq_rdmux.sv
module ep_irq_rdmux
  import ep_irq_pkg::*;
#(
  parameter int NUM_EP = 5,
  parameter int EPW    = 3
) (
  input  logic [NUM_EP-1:0][REG_W-1:0] flag_all,
  input  logic [NUM_EP-1:0][REG_W-1:0] stat_all,
  input  logic [NUM_EP-1:0][REG_W-1:0] en_all,
  input  logic [EPW-1:0]               ep_sel,
  input  logic [1:0]                   reg_sel,
  output logic [REG_W-1:0]             rd_data
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel);

  always_comb begin
    rd_data = '0;
    for (int e = 0; e < NUM_EP; e++) begin
      if (ep_sel == EPW'(e)) begin
        unique case (sel)
          SEL_FLAG: rd_data = flag_all[e];
          SEL_STAT: rd_data = stat_all[e];
          SEL_EN:   rd_data = en_all[e];
          SEL_NONE: rd_data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/ep_irq_agg.sv
module ep_irq_agg
  import ep_irq_pkg::*;
#(
  parameter int NUM_EP = 5,
  parameter int EPW    = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ev_in_rdy,
  input  logic [NUM_EP-1:0] ev_out_rx,
  input  logic [NUM_EP-1:0] ev_setup_rx,
  input  logic [NUM_EP-1:0] ev_stall,
  input  logic [NUM_EP-1:0] ev_iso_crc,
  input  logic [NUM_EP-1:0] ev_ovf,
  input  logic [NUM_EP-1:0] ev_udf,
  input  logic [NUM_EP-1:0] ev_nak_in,
  input  logic [NUM_EP-1:0] ev_nak_out,
  input  logic [NUM_EP-1:0] iso_mode,
  input  logic [EPW-1:0]    ep_sel,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [NUM_EP-1:0] ep_irq,
  output logic              ep_any_irq
);
  // Named internal state, visible to the bound checker.
  logic [NUM_EP-1:0][REG_W-1:0] flag_all;
  logic [NUM_EP-1:0][REG_W-1:0] stat_all;
  logic [NUM_EP-1:0][REG_W-1:0] en_all;
  logic [NUM_EP-1:0]            ep_hit;
  logic [NUM_EP-1:0]            wr_flag_vec;
  logic [NUM_EP-1:0]            wr_stat_vec;
  logic [NUM_EP-1:0]            wr_ena_vec;

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_sel);

  genvar g;
  generate
    for (g = 0; g < NUM_EP; g++) begin : g_ep
      assign ep_hit[g]      = wr_en && (ep_sel == EPW'(g));
      assign wr_flag_vec[g] = ep_hit[g] && (sel == SEL_FLAG);
      assign wr_stat_vec[g] = ep_hit[g] && (sel == SEL_STAT);
      assign wr_ena_vec[g]  = ep_hit[g] && (sel == SEL_EN);

      ep_irq_slot u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_in_rdy   (ev_in_rdy[g]),
        .ev_out_rx   (ev_out_rx[g]),
        .ev_setup_rx (ev_setup_rx[g]),
        .ev_stall    (ev_stall[g]),
        .ev_iso_crc  (ev_iso_crc[g]),
        .ev_ovf      (ev_ovf[g]),
        .ev_udf      (ev_udf[g]),
        .ev_nak_in   (ev_nak_in[g]),
        .ev_nak_out  (ev_nak_out[g]),
        .iso_mode    (iso_mode[g]),
        .wr_flag     (wr_flag_vec[g]),
        .wr_stat     (wr_stat_vec[g]),
        .wr_ena      (wr_ena_vec[g]),
        .wdata       (wr_data),
        .flags_q     (flag_all[g]),
        .stat_q      (stat_all[g]),
        .en_q        (en_all[g]),
        .irq         (ep_irq[g])
      );
    end
  endgenerate

  ep_irq_rdmux #(
    .NUM_EP (NUM_EP),
    .EPW    (EPW)
  ) u_rdmux (
    .flag_all (flag_all),
    .stat_all (stat_all),
    .en_all   (en_all),
    .ep_sel   (ep_sel),
    .reg_sel  (reg_sel),
    .rd_data  (rd_data)
  );

  assign ep_any_irq = |ep_irq;
endmodule

// File: rtl/ep_irq_agg_chk.sv
module ep_irq_agg_chk
  import ep_irq_pkg::*;
#(
  parameter int NUM_EP = 5,
  parameter int EPW    = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_EP-1:0]            ev_in_rdy,
  input logic [NUM_EP-1:0]            ev_iso_crc,
  input logic [NUM_EP-1:0]            ev_stall,
  input logic [NUM_EP-1:0]            ev_udf,
  input logic [NUM_EP-1:0]            ev_nak_in,
  input logic [NUM_EP-1:0]            iso_mode,
  input logic [EPW-1:0]               ep_sel,
  input logic [1:0]                   reg_sel,
  input logic                         wr_en,
  input logic [REG_W-1:0]             wr_data,
  input logic [REG_W-1:0]             rd_data,
  input logic [NUM_EP-1:0]            ep_irq,
  input logic                         ep_any_irq,
  input logic [NUM_EP-1:0][REG_W-1:0] flag_all,
  input logic [NUM_EP-1:0][REG_W-1:0] stat_all,
  input logic [NUM_EP-1:0][REG_W-1:0] en_all
);
  AST_ANY_NEEDS_EP: assert property (@(posedge clk) disable iff (!rst_n)
    ep_any_irq |-> (ep_irq != '0)); // R9
  AST_EP_DRIVES_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_irq != '0) |-> ep_any_irq); // R9
  AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd3) |-> (rd_data == '0)); // R10

  genvar g;
  generate
    for (g = 0; g < NUM_EP; g++) begin : g_chk
      AST_IN_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_in_rdy[g] |=> flag_all[g][B_IN]); // R2
      AST_NO_SET_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_all[g][B_IN] && !ev_in_rdy[g]) |=> !flag_all[g][B_IN]); // R5
      AST_CRC_NEEDS_ISO: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_all[g][B_STALL] && !ev_stall[g] && !iso_mode[g])
          |=> !flag_all[g][B_STALL]); // R3
      AST_UDF_NEEDS_ISO: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_all[g][B_UDF] && !(ev_udf[g] && iso_mode[g]))
          |=> !stat_all[g][B_UDF]); // R4
      AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_nak_in[g] && wr_en && ep_sel == EPW'(g) && reg_sel == 2'd0 &&
         !wr_data[B_NAKIN]) |=> flag_all[g][B_NAKIN]); // R6
      AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ep_irq[g] |-> (en_all[g] != '0)); // R8
      AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ep_irq[g] |-> ((flag_all[g] | stat_all[g]) != '0)); // R8
    end
  endgenerate
endmodule

bind ep_irq_agg ep_irq_agg_chk #(
  .NUM_EP (NUM_EP),
  .EPW    (EPW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_in_rdy  (ev_in_rdy),
  .ev_iso_crc (ev_iso_crc),
  .ev_stall   (ev_stall),
  .ev_udf     (ev_udf),
  .ev_nak_in  (ev_nak_in),
  .iso_mode   (iso_mode),
  .ep_sel     (ep_sel),
  .reg_sel    (reg_sel),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .ep_irq     (ep_irq),
  .ep_any_irq (ep_any_irq),
  .flag_all   (flag_all),
  .stat_all   (stat_all),
  .en_all     (en_all)
);

// File: tb/ep_irq_agg_tb.sv
module ep_irq_agg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] ev_in_rdy, ev_out_rx, ev_setup_rx, ev_stall, ev_iso_crc;
  logic [N-1:0] ev_ovf, ev_udf, ev_nak_in, ev_nak_out, iso_mode;
  logic [2:0] ep_sel;
  logic [1:0] reg_sel;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [N-1:0] ep_irq;
  logic       ep_any_irq;

  int checks = 0;
  int bad = 0;

  // Behavioural reference state
  logic [7:0] m_flag [N] = '{default: 8'h00};
  logic [7:0] m_stat [N] = '{default: 8'h00};
  logic [7:0] m_en   [N] = '{default: 8'h00};

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_in_rdy(ev_in_rdy), .ev_out_rx(ev_out_rx), .ev_setup_rx(ev_setup_rx),
    .ev_stall(ev_stall), .ev_iso_crc(ev_iso_crc), .ev_ovf(ev_ovf),
    .ev_udf(ev_udf), .ev_nak_in(ev_nak_in), .ev_nak_out(ev_nak_out),
    .iso_mode(iso_mode), .ep_sel(ep_sel), .reg_sel(reg_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ep_irq(ep_irq), .ep_any_irq(ep_any_irq)
  );

  // Model update: write clears happen first, events then set bits.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N; e++) begin
        m_flag[e] <= 8'h00; m_stat[e] <= 8'h00; m_en[e] <= 8'h00;
      end
    end else begin
      for (int e = 0; e < N; e++) begin
        logic [7:0] f, s;
        f = m_flag[e];
        s = m_stat[e];
        if (wr_en && ep_sel == e && reg_sel == 2'd0) f = f & wr_data;
        if (wr_en && ep_sel == e && reg_sel == 2'd1) s = s & wr_data;
        if (ev_in_rdy[e])   f[0] = 1'b1;
        if (ev_stall[e] || (ev_iso_crc[e] && iso_mode[e])) f[1] = 1'b1;
        if (ev_out_rx[e])   f[2] = 1'b1;
        if (ev_setup_rx[e]) f[3] = 1'b1;
        if (ev_nak_out[e])  f[4] = 1'b1;
        if (ev_nak_in[e])   f[6] = 1'b1;
        if (ev_ovf[e])      s[6] = 1'b1;
        if (ev_udf[e] && iso_mode[e]) s[5] = 1'b1;
        m_flag[e] <= f;
        m_stat[e] <= s;
        if (wr_en && ep_sel == e && reg_sel == 2'd2) m_en[e] <= {wr_data[7:6], 1'b0, wr_data[4:0]};
      end
    end
  end

  function automatic logic m_irq(int e);
    logic hit;
    hit = 1'b0;
    for (int b = 0; b < 8; b++)
      if (b != 5 && b != 7 && m_flag[e][b] && m_en[e][b]) hit = 1'b1;
    if ((m_stat[e][5] || m_stat[e][6]) && m_en[e][7]) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic [7:0] m_read();
    if (ep_sel >= N) return 8'h00;
    case (reg_sel)
      2'd0: return m_flag[ep_sel];
      2'd1: return m_stat[ep_sel];
      2'd2: return m_en[ep_sel];
      default: return 8'h00;
    endcase
  endfunction

  task automatic idle_inputs();
    {ev_in_rdy, ev_out_rx, ev_setup_rx, ev_stall, ev_iso_crc} = '0;
    {ev_ovf, ev_udf, ev_nak_in, ev_nak_out} = '0;
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic nxt();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic chk(input string tag);
    logic [N-1:0] ei;
    logic [7:0]   er;
    #(CLK_PERIOD/4);
    for (int e = 0; e < N; e++) ei[e] = m_irq(e);
    er = m_read();
    checks += 3;
    if (ep_irq !== ei) begin
      bad++; $display("FAIL %s ep_irq act=%h exp=%h", tag, ep_irq, ei);
    end
    if (ep_any_irq !== (|ei)) begin
      bad++; $display("FAIL %s ep_any_irq act=%b exp=%b", tag, ep_any_irq, |ei);
    end
    if (rd_data !== er) begin
      bad++; $display("FAIL %s rd_data ep=%0d reg=%0d act=%h exp=%h",
                      tag, ep_sel, reg_sel, rd_data, er);
    end
  endtask

  task automatic rd(input int e, input int r, input string tag);
    nxt(); ep_sel = 3'(e); reg_sel = 2'(r); chk(tag);
  endtask

  task automatic wr(input int e, input int r, input logic [7:0] d, input string tag);
    nxt(); ep_sel = 3'(e); reg_sel = 2'(r); wr_en = 1'b1; wr_data = d; chk(tag);
  endtask

  task automatic read_all(input string tag);
    for (int e = 0; e < N; e++)
      for (int r = 0; r < 3; r++) rd(e, r, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    iso_mode = '0; ep_sel = '0; reg_sel = '0;
    idle_inputs();
    // R1: reset state, also with events applied during reset
    repeat (2) begin nxt(); ev_in_rdy = '1; ev_ovf = '1; chk("R1"); end
    nxt(); rst_n = 1'b1; chk("R1");
    read_all("R1");

    // R2: each event on each endpoint sets its mapped flag, enables off
    for (int e = 0; e < N; e++) begin
      nxt(); ev_in_rdy[e] = 1'b1; ep_sel = 3'(e); reg_sel = 2'd0; chk("R2");
      nxt(); ev_out_rx[e] = 1'b1; ep_sel = 3'(e); chk("R2");
      nxt(); ev_setup_rx[e] = 1'b1; ep_sel = 3'(e); chk("R2");
      nxt(); ev_stall[e] = 1'b1; ep_sel = 3'(e); chk("R2");
      nxt(); ev_nak_out[e] = 1'b1; ep_sel = 3'(e); chk("R2");
      nxt(); ev_nak_in[e] = 1'b1; ep_sel = 3'(e); chk("R2");
      rd(e, 0, "R2");
    end
    // R5: writing ones keeps flags, writing zero clears chosen bits
    wr(2, 0, 8'hFF, "R5");
    rd(2, 0, "R5");
    wr(2, 0, 8'hFA, "R5");
    rd(2, 0, "R5");
    for (int e = 0; e < N; e++) wr(e, 0, 8'h00, "R5");
    read_all("R5");
    wr(1, 0, 8'hFF, "R5");
    rd(1, 0, "R5");

    // R7: enable write masks bit 5
    wr(3, 2, 8'hFF, "R7");
    rd(3, 2, "R7");
    wr(3, 2, 8'h00, "R7");
    rd(3, 2, "R7");

    // R8: summary follows flag AND enable
    wr(0, 2, 8'h04, "R8");
    nxt(); ev_in_rdy[0] = 1'b1; chk("R8");
    rd(0, 0, "R8");
    nxt(); ev_out_rx[0] = 1'b1; chk("R8");
    rd(0, 0, "R8");
    wr(0, 0, 8'hFB, "R8");
    rd(0, 0, "R8");
    wr(0, 2, 8'h40, "R8");
    nxt(); ev_nak_in[4] = 1'b1; chk("R8");
    wr(4, 2, 8'h40, "R9");
    rd(4, 0, "R9");

    // R3: CRC error gated by isochronous mode
    nxt(); ev_iso_crc[1] = 1'b1; ep_sel = 3'd1; reg_sel = 2'd0; chk("R3");
    rd(1, 0, "R3");
    iso_mode[1] = 1'b1;
    nxt(); ev_iso_crc[1] = 1'b1; chk("R3");
    rd(1, 0, "R3");

    // R4: overflow any mode, underflow only isochronous
    nxt(); ev_udf[2] = 1'b1; ep_sel = 3'd2; reg_sel = 2'd1; chk("R4");
    rd(2, 1, "R4");
    nxt(); ev_ovf[2] = 1'b1; chk("R4");
    rd(2, 1, "R4");
    iso_mode[2] = 1'b1;
    nxt(); ev_udf[2] = 1'b1; chk("R4");
    rd(2, 1, "R4");
    // R8: bit 7 gates both status bits
    wr(2, 2, 8'h80, "R8");
    rd(2, 1, "R8");
    // R11: status clear semantics
    wr(2, 1, 8'hFF, "R11");
    rd(2, 1, "R11");
    wr(2, 1, 8'hBF, "R11");
    rd(2, 1, "R11");
    wr(2, 1, 8'h00, "R11");
    rd(2, 1, "R11");
    nxt(); ev_udf[2] = 1'b1; chk("R8");
    rd(2, 1, "R8");
    wr(2, 1, 8'h00, "R11");

    // R6: event and clearing write in the same cycle
    nxt(); ev_nak_in[3] = 1'b1; chk("R6");
    nxt(); ev_nak_in[3] = 1'b1; ep_sel = 3'd3; reg_sel = 2'd0;
    wr_en = 1'b1; wr_data = 8'h00; chk("R6");
    rd(3, 0, "R6");
    nxt(); ev_ovf[3] = 1'b1; ep_sel = 3'd3; reg_sel = 2'd1;
    wr_en = 1'b1; wr_data = 8'h00; chk("R6");
    rd(3, 1, "R6");

    // R10: out-of-range endpoints and register code 3
    for (int e = 5; e < 8; e++) begin
      for (int r = 0; r < 4; r++) begin
        wr(e, r, 8'h00, "R10");
        rd(e, r, "R10");
      end
    end
    wr(3, 3, 8'h00, "R10");
    rd(3, 3, "R10");
    read_all("R10");

    // Mixed traffic against the model
    iso_mode = 5'b10110;
    for (int i = 0; i < 2000; i++) begin
      nxt();
      ev_in_rdy   = 5'($urandom) & 5'($urandom);
      ev_out_rx   = 5'($urandom) & 5'($urandom);
      ev_setup_rx = 5'($urandom) & 5'($urandom) & 5'($urandom);
      ev_stall    = 5'($urandom) & 5'($urandom) & 5'($urandom);
      ev_iso_crc  = 5'($urandom) & 5'($urandom);
      ev_ovf      = 5'($urandom) & 5'($urandom) & 5'($urandom);
      ev_udf      = 5'($urandom) & 5'($urandom);
      ev_nak_in   = 5'($urandom) & 5'($urandom);
      ev_nak_out  = 5'($urandom) & 5'($urandom);
      ep_sel  = 3'($urandom);
      reg_sel = 2'($urandom);
      wr_en   = ($urandom % 3) == 0;
      wr_data = 8'($urandom);
      if (i % 200 == 199) iso_mode = 5'($urandom);
      chk("R8");
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule